// File: doc/BRIEF.md
# Display List Instruction Fetcher

This block walks a list of display instructions held in system memory. When a new mode line begins and fetching is enabled, it reads the byte the list pointer addresses and places it in the instruction register. It then steps the pointer. The step touches only the pointer's low 10 bits, so a list that runs off the end of a 1 KiB page wraps to the start of that same page. The block keeps no record of where the list began. A list repeats only by jumping back or by the processor rewriting the pointer.

A byte whose low nibble is 0x1 is a jump. For a jump, the block reads two more bytes, low first and then high, through the same stepping pointer. It then loads all 16 bits, so the target may lie on any page. If bit 6 of the jump byte is set, the block then parks and stops fetching until a vertical-blank pulse arrives. Bit 7 of any instruction requests a one-cycle display interrupt. While parked, a jump with bit 7 set fires that interrupt again on every line start until vertical blank. The processor may rewrite either pointer byte at any moment, and the change is live at once.

Top module: `dlist_fetcher`

## Requirements
- R1: After reset the pointer (seen on mem_addr) is 0x0000, ir is 0x00, dli is 0 and mem_req is 0.
- R2: A pointer step adds one to bits [9:0] only; bits [15:10] never change on a step, so 0x23FF steps to 0x2000.
- R3: A line_start while idle with dma_en high raises mem_req at the pointer and holds it until mem_ack. On that acknowledge the byte goes to ir and the pointer steps.
- R4: An instruction with low nibble 0x1 is a jump. The next two bytes (low, then high) are fetched through the stepping pointer, and the full 16-bit pointer then becomes {high, low}.
- R5: A cpu_wr_lo or cpu_wr_hi write replaces only bits [7:0] or [15:8] of the pointer at the next edge and leaves the other byte unchanged, at any time.
- R6: An instruction byte with bit 7 set gives a single-cycle dli pulse in the cycle after its acknowledge.
- R7: A jump with bit 6 set (0x41 form) parks after loading the pointer. While parked, line_start starts no fetch and the pointer holds, until vblank is high on an edge.
- R8: While parked after a jump with bit 7 set (0xC1), every line_start without vblank gives one dli pulse. A line_start coinciding with vblank gives none and ends the wait.
- R9: With dma_en low no fetch is requested and the pointer holds, while CPU pointer writes still take effect.
- R10: If a CPU byte write and a pointer step fall in one cycle, the written byte takes the CPU value and the other byte takes its stepped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Enables list fetching |
| line_start | input | 1 | Pulse marking a new mode line |
| vblank | input | 1 | Vertical-blank pulse, ends a wait |
| cpu_wr_lo | input | 1 | Write strobe for pointer low byte |
| cpu_wr_hi | input | 1 | Write strobe for pointer high byte |
| cpu_wdata | input | 8 | CPU write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Read address, always the live pointer |
| mem_ack | input | 1 | Read acknowledge with valid data |
| mem_rdata | input | 8 | Read data |
| ir | output | 8 | Instruction register |
| dli | output | 1 | Display interrupt request pulse |

## Verification
Two things can land on the pointer in the same cycle: a CPU byte write and the step that follows an acknowledged fetch. The bench provokes this by raising cpu_wr_hi on exactly the cycle its memory model acknowledges an instruction byte. It judges the result against a pointer built from the CPU high byte and the stepped low byte. A second collision, a line start arriving with vertical blank during a wait, is checked for the absence of an interrupt and for a clean resume.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OP   = 3'd1,
        ST_LO   = 3'd2,
        ST_HI   = 3'd3,
        ST_WAIT = 3'd4
    } fetch_st_e;
endpackage

// File: rtl/dlf_decode.sv
module dlf_decode #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op,
    output logic              is_jump,
    output logic              is_wait,
    output logic              irq_en
);
    always_comb begin
        is_jump = (op[3:0] == 4'h1);
        is_wait = is_jump && op[6];
        irq_en  = op[DATA_W-1];
    end
endmodule

// File: rtl/dlf_ptr.sv
module dlf_ptr #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 10,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] ptr_q,
    input  logic              step,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr_d
);
    localparam int HI_W = ADDR_W - PAGE_W;
    logic [ADDR_W-1:0] base;
    logic [PAGE_W-1:0] low_next;

    always_comb begin
        low_next = ptr_q[PAGE_W-1:0] + PAGE_W'(1);
        if (load)
            base = load_val;
        else if (step)
            base = {ptr_q[ADDR_W-1 -: HI_W], low_next};
        else
            base = ptr_q;
        ptr_d = base;
        if (wr_lo) ptr_d[DATA_W-1:0]        = wdata;
        if (wr_hi) ptr_d[ADDR_W-1 -: DATA_W] = wdata;
    end
endmodule

// File: rtl/dlist_fetcher.sv
module dlist_fetcher #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              line_start,
    input  logic              vblank,
    input  logic              cpu_wr_lo,
    input  logic              cpu_wr_hi,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] ir,
    output logic              dli
);
    import dlf_pkg::*;

    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] jlo;
        logic              dli;
    } regs_t;

    regs_t r_q, r_d;

    logic              fetching, accepted, in_step, in_load, in_wait;
    logic [ADDR_W-1:0] load_val, ptr_nxt;
    logic              rd_jump, rd_wait, rd_irq;
    logic              ir_jump, ir_wait, ir_irq;

    assign fetching = dma_en && (r_q.st == ST_OP || r_q.st == ST_LO || r_q.st == ST_HI);
    assign accepted = fetching && mem_ack;
    assign in_wait  = (r_q.st == ST_WAIT);
    assign load_val = ADDR_W'({mem_rdata, r_q.jlo});

    always_comb begin
        in_step = accepted && (r_q.st == ST_OP || r_q.st == ST_LO);
        in_load = accepted && (r_q.st == ST_HI);
    end

    dlf_decode #(.DATA_W(DATA_W)) u_dec_rd (
        .op(mem_rdata), .is_jump(rd_jump), .is_wait(rd_wait), .irq_en(rd_irq)
    );

    dlf_decode #(.DATA_W(DATA_W)) u_dec_ir (
        .op(r_q.ir), .is_jump(ir_jump), .is_wait(ir_wait), .irq_en(ir_irq)
    );

    dlf_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_ptr (
        .ptr_q(r_q.ptr), .step(in_step), .load(in_load), .load_val(load_val),
        .wr_lo(cpu_wr_lo), .wr_hi(cpu_wr_hi), .wdata(cpu_wdata), .ptr_d(ptr_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.dli = 1'b0;
        r_d.ptr = ptr_nxt;
        case (r_q.st)
            ST_IDLE: if (line_start && dma_en) r_d.st = ST_OP;
            ST_OP: if (accepted) begin
                r_d.ir  = mem_rdata;
                r_d.dli = rd_irq;
                r_d.st  = rd_jump ? ST_LO : ST_IDLE;
            end
            ST_LO: if (accepted) begin
                r_d.jlo = mem_rdata;
                r_d.st  = ST_HI;
            end
            ST_HI: if (accepted) begin
                r_d.st = ir_wait ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT: begin
                if (vblank)
                    r_d.st = ST_IDLE;
                else if (line_start)
                    r_d.dli = ir_irq;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.ptr <= '0;
            r_q.ir  <= '0;
            r_q.jlo <= '0;
            r_q.dli <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = fetching;
    assign mem_addr = r_q.ptr;
    assign ir       = r_q.ir;
    assign dli      = r_q.dli;
    logic unused_ok;
    assign unused_ok = ir_jump;
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_en,
    input logic              line_start,
    input logic              cpu_wr_lo,
    input logic              cpu_wr_hi,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dli,
    input logic              in_step,
    input logic              in_load,
    input logic              in_wait
);
    localparam int HI_W = ADDR_W - PAGE_W;

    // R2
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_step && !cpu_wr_lo && !cpu_wr_hi |=>
            mem_addr[ADDR_W-1 -: HI_W] == $past(mem_addr[ADDR_W-1 -: HI_W]) &&
            mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + PAGE_W'(1));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && dma_en |=> mem_req);

    // R5
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_lo && !cpu_wr_hi && !in_step && !in_load |=>
            mem_addr[DATA_W-1:0] == $past(cpu_wdata) &&
            mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W]));

    // R6
    dli_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dli |-> $past(mem_req && mem_ack) || $past(line_start));

    // R7
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> !mem_req);

    // R9
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !mem_req);
endmodule

bind dlist_fetcher dlf_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .line_start(line_start),
    .cpu_wr_lo(cpu_wr_lo), .cpu_wr_hi(cpu_wr_hi), .cpu_wdata(cpu_wdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .dli(dli),
    .in_step(in_step), .in_load(in_load), .in_wait(in_wait)
);

// File: tb/dlist_fetcher_tb.sv
module dlist_fetcher_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_en = 1'b1;
    logic        line_start = 1'b0;
    logic        vblank = 1'b0;
    logic        cpu_wr_lo = 1'b0;
    logic        cpu_wr_hi = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  ir;
    logic        dli;

    int checks = 0;
    int errors = 0;
    int dli_cnt = 0;
    bit req_seen = 1'b0;
    bit done = 1'b0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    dlist_fetcher u_dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .line_start(line_start),
        .vblank(vblank), .cpu_wr_lo(cpu_wr_lo), .cpu_wr_hi(cpu_wr_hi),
        .cpu_wdata(cpu_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ir(ir), .dli(dli)
    );

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    function automatic logic [15:0] nxt(input logic [15:0] a);
        return {a[15:10], a[9:0] + 10'd1};
    endfunction

    // memory responder and monitors, all on the falling edge
    initial forever begin
        @(negedge clk);
        mem_ack   = mem_req;
        mem_rdata = rd(mem_addr);
        if (dli) dli_cnt++;
        if (mem_req) req_seen = 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [15:0] v);
        @(negedge clk); cpu_wr_lo = 1'b1; cpu_wdata = v[7:0];
        @(negedge clk); cpu_wr_lo = 1'b0; cpu_wr_hi = 1'b1; cpu_wdata = v[15:8];
        @(negedge clk); cpu_wr_hi = 1'b0;
    endtask

    task automatic run_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_vblank();
        @(negedge clk); vblank = 1'b1;
        @(negedge clk); vblank = 1'b0;
    endtask

    // start, op, jump low, jump high, expected pointer, expected dli pulses
    localparam logic [56:0] VEC [6] = '{
        {16'h1000, 8'h02, 8'h00, 8'h00, 16'h1001, 1'b0},  // R3 plain fetch
        {16'h23FF, 8'h0F, 8'h00, 8'h00, 16'h2000, 1'b0},  // R2 page wrap
        {16'h2000, 8'h82, 8'h00, 8'h00, 16'h2001, 1'b1},  // R6 interrupt bit
        {16'h13FE, 8'h01, 8'h34, 8'hAB, 16'hAB34, 1'b0},  // R4 jump, operand wraps
        {16'h4000, 8'h81, 8'h67, 8'h05, 16'h0567, 1'b1},  // R4 R6 jump with irq
        {16'h5000, 8'h41, 8'hBC, 8'h9A, 16'h9ABC, 1'b0}   // R7 jump and wait
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", 32'(mem_addr), 32'h0000);
        chk("R1 ir", 32'(ir), 32'h00);
        chk("R1 dli", 32'(dli), 32'h0);
        chk("R1 req", 32'(mem_req), 32'h0);

        foreach (VEC[i]) begin
            logic [15:0] st, ex;
            logic [7:0] op, lo, hi;
            {st, op, lo, hi, ex} = VEC[i][56:1];
            mem[int'(st)] = op;
            if (op[3:0] == 4'h1) begin
                mem[int'(nxt(st))] = lo;
                mem[int'(nxt(nxt(st)))] = hi;
            end
            set_ptr(st);
            dli_cnt = 0;
            run_line();
            chk($sformatf("R3 ir vec%0d", i), 32'(ir), 32'(op));
            chk($sformatf("R2 R4 ptr vec%0d", i), 32'(mem_addr), 32'(ex));
            chk($sformatf("R6 dli vec%0d", i), 32'(dli_cnt), 32'(VEC[i][0]));
            if (op[3:0] == 4'h1 && op[6]) pulse_vblank();
        end

        // R5 single byte writes
        set_ptr(16'h1234);
        @(negedge clk); cpu_wr_hi = 1'b1; cpu_wdata = 8'h56;
        @(negedge clk); cpu_wr_hi = 1'b0;
        chk("R5 high byte only", 32'(mem_addr), 32'h5634);
        cpu_wr_lo = 1'b1; cpu_wdata = 8'h9A;
        @(negedge clk); cpu_wr_lo = 1'b0;
        chk("R5 low byte only", 32'(mem_addr), 32'h569A);

        // R7 R8 wait with repeated interrupts
        mem[32'h6000] = 8'hC1; mem[32'h6001] = 8'h00; mem[32'h6002] = 8'h70;
        set_ptr(16'h6000);
        dli_cnt = 0;
        run_line();
        chk("R8 first dli", 32'(dli_cnt), 32'd1);
        chk("R4 wait target", 32'(mem_addr), 32'h7000);
        dli_cnt = 0; req_seen = 1'b0;
        for (int k = 0; k < 3; k++) run_line();
        chk("R8 repeated dli", 32'(dli_cnt), 32'd3);
        chk("R7 no fetch while parked", 32'(req_seen), 32'd0);
        chk("R7 ptr held", 32'(mem_addr), 32'h7000);
        @(negedge clk); vblank = 1'b1; line_start = 1'b1;
        @(negedge clk); vblank = 1'b0; line_start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 no dli with vblank", 32'(dli_cnt), 32'd3);
        mem[32'h7000] = 8'h02;
        dli_cnt = 0;
        run_line();
        chk("R7 resume ir", 32'(ir), 32'h02);
        chk("R7 resume ptr", 32'(mem_addr), 32'h7001);
        chk("R8 no dli after wait", 32'(dli_cnt), 32'd0);

        // R9 DMA gating
        @(negedge clk); dma_en = 1'b0; req_seen = 1'b0;
        cpu_wr_lo = 1'b1; cpu_wdata = 8'h55;
        @(negedge clk); cpu_wr_lo = 1'b0;
        run_line();
        chk("R9 write accepted", 32'(mem_addr), 32'h7055);
        chk("R9 no request", 32'(req_seen), 32'd0);
        chk("R9 ir held", 32'(ir), 32'h02);
        @(negedge clk); dma_en = 1'b1;

        // R10 CPU write collides with a pointer step
        mem[32'h3000] = 8'h02;
        set_ptr(16'h3000);
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0; cpu_wr_hi = 1'b1; cpu_wdata = 8'h77;
        @(negedge clk); cpu_wr_hi = 1'b0;
        chk("R10 merged ptr", 32'(mem_addr), 32'h7701);
        chk("R10 ir", 32'(ir), 32'h02);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule